// File: doc/BRIEF.md
# Erase-Program-Verify Sequencer for a Byte-Wide Reprogrammable ROM

This block acts as the external programming station for a byte-wide, electrically erasable memory that has a standard ROM pinout. After a single `start` pulse it runs a fixed four-phase job:

1. A whole-array erase under both high voltages.
2. A blank check that every location reads all ones.
3. A byte-by-byte write of an image that it pulls from a request/acknowledge source port.
4. A final read-back that compares every location with that image.

The sequencer drives the memory's address and write data, its active-low chip select, read enable and write strobe, and two enables for external high-voltage switches. One switch feeds the programming supply. The other lifts the special address pin that selects whole-array erase.

Every interval is a parameter given in microseconds or nanoseconds. It is turned into clock cycles from the `CLK_HZ` parameter, rounding up. The intervals are:
- the high-voltage setup and hold times;
- the erase and write pulse widths;
- the recovery time before any read;
- the read access time.

The sequencer stops at the first byte that does not match. It then holds `fail`, the failing address, and the expected and observed bytes until the next `start`. The highest address written is the parameter `LAST_ADDR`, so a small array can stand in for a full part.

Top module: `flash_prog_seq`

## Requirements
- R1: While reset is held and whenever the block is idle, it shows `busy`=0, chip select, read enable and write strobe high (inactive), and both high-voltage enables low. Reset also clears `pass` and `fail`.
- R2: Erase raises the high-voltage pin enable and the programming-supply enable together. Both stay on for at least SETUP cycles before the strobe falls. The strobe is then low for exactly ERASE cycles. Both enables stay on for at least HOLD cycles after the strobe rises.
- R3: The read enable is never low while either high-voltage enable is on. The first read after any high-voltage removal comes at least RECOV cycles after the removal.
- R4: The blank check reads addresses 0 to `LAST_ADDR` in ascending order and compares each with all ones. On the first mismatch it sets `fail` and reports that address, expected 0xFF and the observed byte. It returns to idle without ever applying programming voltage again.
- R5: The write phase issues exactly one strobe per address, from 0 to `LAST_ADDR` in ascending order. Each strobe is low for exactly PROG cycles, with the programming supply on and the high-voltage pin enable off.
- R6: Address and write data are unchanged from at least SETUP cycles before each strobe falls until at least HOLD cycles after it rises. The programming supply is on for at least SETUP cycles before the strobe falls and stays on at least HOLD cycles after the last strobe rises.
- R7: Throughout the write phase, chip select is low and read enable is high. Chip select has been low at least SETUP cycles before each strobe.
- R8: Each image byte is requested by holding `src_req` high with a stable `src_addr` until `src_ack`. The byte on `src_data` in the acknowledge cycle is the one written, and later compared, for that address.
- R9: After the last write and the recovery interval, the sequencer reads every address in ascending order and compares it with the image byte. A full match ends the run with `pass`=1 and `fail`=0.
- R10: A read-back mismatch sets `fail` and latches the address, the image byte and the observed byte. `pass` and `fail` are never high together. They hold until the next accepted `start`, which clears both in the cycle `busy` rises.
- R11: A `start` pulse while `busy` is high is ignored: the run in progress continues and erases the array only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a run (taken only when idle) |
| src_req | output | 1 | Image byte request |
| src_addr | output | ADDR_W | Address of the requested image byte |
| src_ack | input | 1 | Image byte valid on `src_data` this cycle |
| src_data | input | DATA_W | Image byte |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Data presented to the memory for writing |
| mem_rdata | input | DATA_W | Data read from the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Read enable, active low |
| mem_pgm_n | output | 1 | Write/erase strobe, active low |
| vpp_en | output | 1 | Programming-supply switch enable |
| a9_hv_en | output | 1 | High-voltage enable for the erase-select address pin |
| busy | output | 1 | Run in progress |
| pass | output | 1 | Last run completed with all bytes matching |
| fail | output | 1 | Last run stopped on a mismatch |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_exp | output | DATA_W | Expected byte at the mismatch |
| fail_act | output | DATA_W | Observed byte at the mismatch |

## Verification
- `busy` rises, and `pass` and `fail` clear, on the first edge after `start` is sampled. The bench therefore checks them at the next falling edge.
- Each interval has a known length in cycles: strobe width, setup, hold and recovery. The bench recomputes these lengths from its own copy of the parameters. It keeps per-signal age counters that it updates at every falling edge. When a strobe edge, a high-voltage removal or a read start appears, it compares the counted age with the required count.
- `pass` or `fail` is due one edge after the compare cycle of the final or mismatching read. The bench waits for `busy` to fall and checks the latched address and bytes in that same sample.

// File: rtl/flash_prog_pkg.sv
// Shared types and helper functions for the erase-program-verify sequencer.
// Assumes interval parameters are small enough that cycles fit in 32 bits.
package flash_prog_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_E_SETUP,
        ST_E_PULSE,
        ST_E_HOLD,
        ST_E_RECOV,
        ST_EV_READ,
        ST_P_VPP,
        ST_P_FETCH,
        ST_P_SETUP,
        ST_P_PULSE,
        ST_P_HOLD,
        ST_P_RECOV,
        ST_V_FETCH,
        ST_V_READ
    } seq_state_t;

    // Microseconds to clock cycles, rounded up, never below one cycle.
    function automatic int unsigned us_to_cyc(input int unsigned hz, input int unsigned us);
        logic [63:0] c;
        c = (64'(hz) * 64'(us) + 64'd999_999) / 64'd1_000_000;
        if (c == 64'd0) c = 64'd1;
        return c[31:0];
    endfunction

    // Nanoseconds to clock cycles, rounded up, never below one cycle.
    function automatic int unsigned ns_to_cyc(input int unsigned hz, input int unsigned ns);
        logic [63:0] c;
        c = (64'(hz) * 64'(ns) + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 64'd0) c = 64'd1;
        return c[31:0];
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/fps_timer.sv
// Down-counting interval timer. A load with value N-1 makes zero rise after
// N-1 further cycles, so a state that loads on entry and leaves on zero
// lasts exactly N cycles. Assumes load_val fits in CNT_W bits.
module fps_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    // Count down to zero; a load takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt <= '0;
        else if (load)            cnt <= load_val;
        else if (cnt != '0)       cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/fps_addr_ctr.sv
// Address walker for the sequencer's passes. Clears to zero, steps by one,
// and flags the configured final address. Assumes LAST_ADDR < 2**ADDR_W.
module fps_addr_ctr #(
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned LAST_ADDR = 255
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              inc,
    output logic [ADDR_W-1:0] addr,
    output logic              at_last
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LAST_ADDR);

    // Hold, clear or advance the current address.
    always_ff @(posedge clk) begin
        if (!rst_n)     addr <= '0;
        else if (clr)   addr <= '0;
        else if (inc)   addr <= addr + 1'b1;
    end

    assign at_last = (addr == LAST);
endmodule

// File: rtl/flash_prog_seq.sv
// Erase, blank-check, program and verify sequencer for a byte-wide
// electrically erasable memory. Uses the separate write-strobe scheme: chip
// select low and read enable high while the strobe pulses. All intervals are
// given in time units and turned into cycles from CLK_HZ. Assumes the
// external switches follow vpp_en / a9_hv_en with negligible delay and that
// src_ack is a one-cycle acknowledge of the current request.
module flash_prog_seq
    import flash_prog_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned ADDR_W    = 18,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned LAST_ADDR = 262_143,
    parameter int unsigned ERASE_US  = 100_000,
    parameter int unsigned PROG_US   = 20,
    parameter int unsigned SETUP_US  = 1,
    parameter int unsigned HOLD_US   = 1,
    parameter int unsigned RECOV_US  = 1,
    parameter int unsigned ACCESS_NS = 70
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              src_req,
    output logic [ADDR_W-1:0] src_addr,
    input  logic              src_ack,
    input  logic [DATA_W-1:0] src_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_pgm_n,
    output logic              vpp_en,
    output logic              a9_hv_en,
    output logic              busy,
    output logic              pass,
    output logic              fail,
    output logic [ADDR_W-1:0] fail_addr,
    output logic [DATA_W-1:0] fail_exp,
    output logic [DATA_W-1:0] fail_act
);
    localparam int unsigned SETUP_CYC = us_to_cyc(CLK_HZ, SETUP_US);
    localparam int unsigned HOLD_CYC  = us_to_cyc(CLK_HZ, HOLD_US);
    localparam int unsigned RECOV_CYC = us_to_cyc(CLK_HZ, RECOV_US);
    localparam int unsigned ERASE_CYC = us_to_cyc(CLK_HZ, ERASE_US);
    localparam int unsigned PROG_CYC  = us_to_cyc(CLK_HZ, PROG_US);
    localparam int unsigned ACC_CYC   = ns_to_cyc(CLK_HZ, ACCESS_NS);
    localparam int unsigned MAX_CYC   = max2(max2(ERASE_CYC, PROG_CYC),
                                             max2(max2(SETUP_CYC, HOLD_CYC),
                                                  max2(RECOV_CYC, ACC_CYC)));
    localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);
    localparam logic [DATA_W-1:0] BLANK = {DATA_W{1'b1}};

    seq_state_t        state, nxt;
    logic              go, tz;
    logic [CNT_W-1:0]  tmr_val;
    logic              addr_clr, addr_inc, at_last;
    logic [ADDR_W-1:0] addr;
    logic              take, fail_set, pass_set;
    logic [DATA_W-1:0] dreg;

    fps_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (go),
        .load_val (tmr_val),
        .zero     (tz)
    );

    fps_addr_ctr #(.ADDR_W(ADDR_W), .LAST_ADDR(LAST_ADDR)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (addr_clr),
        .inc     (addr_inc),
        .addr    (addr),
        .at_last (at_last)
    );

    // Next state, timer load and datapath strobes.
    always_comb begin
        nxt      = state;
        go       = 1'b0;
        addr_clr = 1'b0;
        addr_inc = 1'b0;
        take     = 1'b0;
        fail_set = 1'b0;
        pass_set = 1'b0;
        case (state)
            ST_IDLE:    if (start) begin nxt = ST_E_SETUP; go = 1'b1; addr_clr = 1'b1; end
            ST_E_SETUP: if (tz) begin nxt = ST_E_PULSE; go = 1'b1; end
            ST_E_PULSE: if (tz) begin nxt = ST_E_HOLD;  go = 1'b1; end
            ST_E_HOLD:  if (tz) begin nxt = ST_E_RECOV; go = 1'b1; end
            ST_E_RECOV: if (tz) begin nxt = ST_EV_READ; go = 1'b1; end
            ST_EV_READ: if (tz) begin
                if (mem_rdata != BLANK) begin
                    nxt = ST_IDLE; fail_set = 1'b1;
                end else if (at_last) begin
                    nxt = ST_P_VPP; go = 1'b1; addr_clr = 1'b1;
                end else begin
                    go = 1'b1; addr_inc = 1'b1;
                end
            end
            ST_P_VPP:   if (tz) nxt = ST_P_FETCH;
            ST_P_FETCH: if (src_ack) begin nxt = ST_P_SETUP; go = 1'b1; take = 1'b1; end
            ST_P_SETUP: if (tz) begin nxt = ST_P_PULSE; go = 1'b1; end
            ST_P_PULSE: if (tz) begin nxt = ST_P_HOLD;  go = 1'b1; end
            ST_P_HOLD:  if (tz) begin
                if (at_last) begin nxt = ST_P_RECOV; go = 1'b1; end
                else begin nxt = ST_P_FETCH; addr_inc = 1'b1; end
            end
            ST_P_RECOV: if (tz) begin nxt = ST_V_FETCH; addr_clr = 1'b1; end
            ST_V_FETCH: if (src_ack) begin nxt = ST_V_READ; go = 1'b1; take = 1'b1; end
            ST_V_READ:  if (tz) begin
                if (mem_rdata != dreg) begin
                    nxt = ST_IDLE; fail_set = 1'b1;
                end else if (at_last) begin
                    nxt = ST_IDLE; pass_set = 1'b1;
                end else begin
                    nxt = ST_V_FETCH; addr_inc = 1'b1;
                end
            end
            default:    nxt = ST_IDLE;
        endcase
    end

    // Interval loaded on entry to each timed state (length minus one).
    always_comb begin
        case (nxt)
            ST_E_SETUP, ST_P_VPP, ST_P_SETUP: tmr_val = CNT_W'(SETUP_CYC - 1);
            ST_E_PULSE:                       tmr_val = CNT_W'(ERASE_CYC - 1);
            ST_P_PULSE:                       tmr_val = CNT_W'(PROG_CYC - 1);
            ST_E_HOLD, ST_P_HOLD:             tmr_val = CNT_W'(HOLD_CYC - 1);
            ST_E_RECOV, ST_P_RECOV:           tmr_val = CNT_W'(RECOV_CYC - 1);
            ST_EV_READ, ST_V_READ:            tmr_val = CNT_W'(ACC_CYC - 1);
            default:                          tmr_val = '0;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Image byte capture on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)    dreg <= '0;
        else if (take) dreg <= src_data;
    end

    // Result flags and mismatch record, cleared by an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass      <= 1'b0;
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_exp  <= '0;
            fail_act  <= '0;
        end else if (state == ST_IDLE && start) begin
            pass <= 1'b0;
            fail <= 1'b0;
        end else if (fail_set) begin
            fail      <= 1'b1;
            fail_addr <= addr;
            fail_exp  <= (state == ST_EV_READ) ? BLANK : dreg;
            fail_act  <= mem_rdata;
        end else if (pass_set) begin
            pass <= 1'b1;
        end
    end

    // Pin levels decoded from the state.
    always_comb begin
        a9_hv_en  = (state == ST_E_SETUP) || (state == ST_E_PULSE) || (state == ST_E_HOLD);
        vpp_en    = a9_hv_en || (state == ST_P_VPP) || (state == ST_P_FETCH) ||
                    (state == ST_P_SETUP) || (state == ST_P_PULSE) || (state == ST_P_HOLD);
        mem_pgm_n = !((state == ST_E_PULSE) || (state == ST_P_PULSE));
        mem_oe_n  = !((state == ST_EV_READ) || (state == ST_V_FETCH) || (state == ST_V_READ));
        mem_ce_n  = (state == ST_IDLE);
        busy      = (state != ST_IDLE);
        src_req   = (state == ST_P_FETCH) || (state == ST_V_FETCH);
    end

    assign src_addr  = addr;
    assign mem_addr  = addr;
    assign mem_wdata = dreg;
endmodule

// File: rtl/flash_prog_seq_chk.sv
// Protocol checker for flash_prog_seq, attached by bind below. Observes
// ports only; interval lengths are checked by the bench's age counters.
module flash_prog_seq_chk #(
    parameter int unsigned ADDR_W = 18,
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              src_req,
    input logic              src_ack,
    input logic [ADDR_W-1:0] src_addr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_pgm_n,
    input logic              vpp_en,
    input logic              a9_hv_en,
    input logic              busy,
    input logic              pass,
    input logic              fail
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (mem_ce_n && mem_oe_n && mem_pgm_n && !vpp_en && !a9_hv_en));

    a_r2_pin_hv_needs_vpp: assert property (@(posedge clk) disable iff (!rst_n)
        a9_hv_en |-> vpp_en);

    a_r3_no_read_under_hv: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!vpp_en && !a9_hv_en));

    a_r6_strobe_under_vpp: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_pgm_n |-> vpp_en);

    a_r6_addr_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_pgm_n && $past(!mem_pgm_n)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

    a_r7_write_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        (vpp_en && !a9_hv_en) |-> (!mem_ce_n && mem_oe_n));

    a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req && !src_ack) |=> (src_req && $stable(src_addr)));

    a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass && fail));

    a_r10_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> fail);
endmodule

bind flash_prog_seq flash_prog_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .src_req   (src_req),
    .src_ack   (src_ack),
    .src_addr  (src_addr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_pgm_n (mem_pgm_n),
    .vpp_en    (vpp_en),
    .a9_hv_en  (a9_hv_en),
    .busy      (busy),
    .pass      (pass),
    .fail      (fail)
);

// File: tb/flash_prog_seq_tb.sv
// Bench: behavioural memory, image source and per-cycle timing monitor.
module flash_prog_seq_tb;
    localparam int unsigned HZ     = 4_000_000;
    localparam int unsigned AW     = 5;
    localparam int unsigned LAST   = 15;
    localparam int unsigned E_US   = 250;
    // Expected cycle counts at 4 cycles per microsecond.
    localparam int SETUP_CYC = 4;
    localparam int HOLD_CYC  = 4;
    localparam int RECOV_CYC = 4;
    localparam int PROG_CYC  = 80;
    localparam int ERASE_CYC = 1000;
    localparam int NBYTES    = LAST + 1;

    logic clk = 1'b0;
    logic rst_n, start;
    logic src_req, src_ack;
    logic [AW-1:0] src_addr, mem_addr, fail_addr;
    logic [7:0] src_data, mem_wdata, mem_rdata, fail_exp, fail_act;
    logic mem_ce_n, mem_oe_n, mem_pgm_n, vpp_en, a9_hv_en, busy, pass, fail;

    always #4 clk = ~clk;

    flash_prog_seq #(
        .CLK_HZ(HZ), .ADDR_W(AW), .DATA_W(8), .LAST_ADDR(LAST), .ERASE_US(E_US),
        .PROG_US(20), .SETUP_US(1), .HOLD_US(1), .RECOV_US(1), .ACCESS_NS(70)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_req(src_req), .src_addr(src_addr), .src_ack(src_ack), .src_data(src_data),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_pgm_n(mem_pgm_n),
        .vpp_en(vpp_en), .a9_hv_en(a9_hv_en),
        .busy(busy), .pass(pass), .fail(fail),
        .fail_addr(fail_addr), .fail_exp(fail_exp), .fail_act(fail_act)
    );

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  finished = 0;
    bit  flt_erase = 0;   // erase leaves bit 0 of address 5 at zero
    bit  flt_prog  = 0;   // write to address 9 has no effect

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] img(input int a);
        return 8'h5A ^ 8'(a * 37);
    endfunction

    // Memory model and timing monitor state
    logic [7:0] mem [0:LAST];
    int vpp_age, a9_age, hv_off_age, addr_age, data_age, ce_age, post_age, low_cnt;
    int erase_cnt, prog_cnt, prog_next, rd_next;
    logic p_pgm, p_vpp, p_a9, p_oe, p_ce;
    logic [AW-1:0] p_addr;
    logic [7:0] p_wdata;

    always_comb mem_rdata = (!mem_ce_n && !mem_oe_n && !vpp_en) ? mem[mem_addr[3:0]] : 8'h00;

    // Per-cycle monitor: update ages, check event timing, apply memory effects.
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NBYTES; i++) mem[i] = 8'h00;
            vpp_age = 0; a9_age = 0; hv_off_age = 0; addr_age = 0; data_age = 0;
            ce_age = 0; post_age = 1000; low_cnt = 0;
            erase_cnt = 0; prog_cnt = 0; prog_next = 0; rd_next = 0;
            p_pgm = 1; p_vpp = 0; p_a9 = 0; p_oe = 1; p_ce = 1; p_addr = '0; p_wdata = '0;
        end else begin
            if (start && !busy) begin
                erase_cnt = 0; prog_cnt = 0; prog_next = 0; rd_next = 0;
            end
            vpp_age    = (vpp_en != p_vpp) ? 0 : vpp_age + 1;
            a9_age     = (a9_hv_en != p_a9) ? 0 : a9_age + 1;
            hv_off_age = ((p_vpp || p_a9) && !(vpp_en || a9_hv_en)) ? 0 : hv_off_age + 1;
            addr_age   = (mem_addr != p_addr) ? 0 : addr_age + 1;
            data_age   = (mem_wdata != p_wdata) ? 0 : data_age + 1;
            ce_age     = (mem_ce_n != p_ce) ? 0 : ce_age + 1;
            post_age   = (!p_pgm && mem_pgm_n) ? 0 : post_age + 1;
            if (p_pgm && !mem_pgm_n) low_cnt = 1;
            else if (!mem_pgm_n) low_cnt = low_cnt + 1;

            // strobe falling edge: setup intervals
            if (p_pgm && !mem_pgm_n) begin
                chk(vpp_age >= SETUP_CYC, "R6 vpp setup", vpp_age, SETUP_CYC);
                chk(addr_age >= SETUP_CYC, "R6 addr setup", addr_age, SETUP_CYC);
                if (a9_hv_en) chk(a9_age >= SETUP_CYC, "R2 pin hv setup", a9_age, SETUP_CYC);
                else begin
                    chk(data_age >= SETUP_CYC, "R6 data setup", data_age, SETUP_CYC);
                    chk(ce_age >= SETUP_CYC && mem_oe_n, "R7 ce setup", ce_age, SETUP_CYC);
                end
            end
            // strobe rising edge: width, order, memory effect
            if (!p_pgm && mem_pgm_n) begin
                if (a9_hv_en) begin
                    chk(low_cnt == ERASE_CYC, "R2 erase width", low_cnt, ERASE_CYC);
                    erase_cnt++;
                    for (int i = 0; i < NBYTES; i++) mem[i] = 8'hFF;
                    if (flt_erase) mem[5] = 8'hFE;
                end else begin
                    chk(low_cnt == PROG_CYC, "R5 write width", low_cnt, PROG_CYC);
                    chk(int'(mem_addr) == prog_next, "R5 write order", int'(mem_addr), prog_next);
                    prog_cnt++;
                    prog_next++;
                    if (!(flt_prog && mem_addr == 5'd9)) mem[mem_addr[3:0]] = mem[mem_addr[3:0]] & mem_wdata;
                end
            end
            // address/data change must respect hold
            if ((mem_addr != p_addr || mem_wdata != p_wdata) && p_vpp && !p_a9)
                chk(mem_pgm_n && post_age >= HOLD_CYC, "R6 addr/data hold", post_age, HOLD_CYC);
            // high-voltage removal must respect hold
            if (p_vpp && !vpp_en) begin
                chk(post_age >= HOLD_CYC, p_a9 ? "R2 hv hold" : "R6 vpp hold", post_age, HOLD_CYC);
                rd_next = 0;
            end
            // start of a read: recovery and address order
            if (!mem_oe_n && (p_oe || mem_addr != p_addr)) begin
                if (p_oe)
                    chk(!vpp_en && !a9_hv_en && hv_off_age >= RECOV_CYC, "R3 recovery",
                        hv_off_age, RECOV_CYC);
                chk(int'(mem_addr) == rd_next, (prog_cnt == 0) ? "R4 read order" : "R9 read order",
                    int'(mem_addr), rd_next);
                rd_next++;
            end
            p_pgm = mem_pgm_n; p_vpp = vpp_en; p_a9 = a9_hv_en; p_oe = mem_oe_n;
            p_ce = mem_ce_n; p_addr = mem_addr; p_wdata = mem_wdata;
        end
    end

    // Image source with address-dependent latency (0..2 cycles).
    int lat;
    always @(negedge clk) begin
        if (!rst_n) begin
            src_ack = 0; src_data = 8'h00; lat = 0;
        end else if (src_ack) begin
            src_ack = 0;
        end else if (src_req) begin
            if (lat >= int'(src_addr) % 3) begin
                src_ack = 1; src_data = img(int'(src_addr)); lat = 0;
            end else lat++;
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1;
        @(negedge clk) start = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; start = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !pass && !fail, "R1 flags", {busy, pass, fail}, 0);
        chk(mem_ce_n && mem_oe_n && mem_pgm_n, "R1 strobes", {mem_ce_n, mem_oe_n, mem_pgm_n}, 7);
        chk(!vpp_en && !a9_hv_en, "R1 hv off", {vpp_en, a9_hv_en}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // Run 1: clean run, with an extra start mid-run (R11)
        pulse_start();
        chk(busy && !fail && !pass, "R10 start clears", {busy, pass, fail}, 4);
        repeat (50) @(negedge clk);
        start = 1; @(negedge clk); start = 0;
        wait_idle();
        chk(pass && !fail, "R9 pass", {pass, fail}, 2);
        chk(erase_cnt == 1, "R11 single erase", erase_cnt, 1);
        chk(prog_cnt == NBYTES, "R5 write count", prog_cnt, NBYTES);
        chk(rd_next == NBYTES, "R9 read-back count", rd_next, NBYTES);
        for (int i = 0; i < NBYTES; i++)
            chk(mem[i] == img(i), "R8 image written", mem[i], img(i));
        chk(!vpp_en && mem_ce_n && mem_oe_n, "R1 idle after run", {vpp_en, mem_ce_n, mem_oe_n}, 3);

        // Run 2: stuck bit after erase, blank check must stop (R4)
        flt_erase = 1;
        pulse_start();
        wait_idle();
        chk(fail && !pass, "R4 blank fail", {pass, fail}, 1);
        chk(fail_addr == 5'd5, "R4 fail address", fail_addr, 5);
        chk(fail_exp == 8'hFF, "R4 expected byte", fail_exp, 8'hFF);
        chk(fail_act == 8'hFE, "R4 observed byte", fail_act, 8'hFE);
        chk(prog_cnt == 0, "R4 no writes", prog_cnt, 0);
        chk(rd_next == 6, "R4 reads stop", rd_next, 6);
        repeat (20) @(negedge clk);
        chk(fail && !busy && !vpp_en, "R10 fail held", {fail, busy, vpp_en}, 4);

        // Run 3: a write that does not take, read-back must stop (R10)
        flt_erase = 0; flt_prog = 1;
        pulse_start();
        chk(busy && !fail, "R10 start clears fail", {busy, fail}, 2);
        wait_idle();
        chk(fail && !pass, "R10 verify fail", {pass, fail}, 1);
        chk(fail_addr == 5'd9, "R10 fail address", fail_addr, 9);
        chk(fail_exp == img(9), "R10 expected byte", fail_exp, img(9));
        chk(fail_act == 8'hFF, "R10 observed byte", fail_act, 8'hFF);
        chk(prog_cnt == NBYTES, "R5 all written before verify", prog_cnt, NBYTES);

        finished = 1;
        summary();
        $finish;
    end
endmodule